// File: doc/BRIEF.md
# Memory-Mapped Keyboard and Display Controller

This block links a 16-bit processor bus to a character keyboard source and a character display sink. It decodes four fixed bus addresses: a status word and a data word for each device. A load or store to any other address is flagged so that the surrounding datapath uses ordinary memory instead. Reads are combinational from the address, so the loaded word is present in the same cycle as the read strobe. Side effects of a read or a write take hold at the next rising clock edge.

The ready flags are driven only by the protocol. The keyboard ready flag rises when a character is captured. It falls when the processor loads the keyboard data word. While it is up, new keystrokes are refused and recorded as an overrun. The display ready flag falls when the processor stores a character. It rises again once the display sink has taken that character. Stores that arrive in between are discarded. Each device raises an interrupt request while its ready flag and its enable flag are both set.

Top module: `mmcon_top`

## Requirements
- R1: Address 0xFE00 selects the keyboard status word, 0xFE02 the keyboard data word, 0xFE04 the display status word and 0xFE06 the display data word. For these addresses `mem_sel` is 0. For every other address `mem_sel` is 1 and `bus_rdata` is 0. `bus_rdata` follows `bus_addr` combinationally.
- R2: In a status word, bit 15 is the ready flag, bit 14 is the interrupt-enable flag and all other bits read 0. A store to a status address writes only bit 14. Bit 15 cannot be changed by a store.
- R3: `irq_kbd` is 1 exactly when the keyboard ready flag and enable flag are both 1. `irq_disp` behaves the same way for the display flags.
- R4: When `kbd_valid` is high and the keyboard ready flag is 0, `kbd_char` is placed in data bits 7:0 at the next edge and the ready flag becomes 1. Data bits 15:8 always read 0.
- R5: A read of 0xFE02 while the keyboard ready flag is 1 clears the flag at the next edge. The next keystroke is then captured.
- R6: A keystroke that arrives while the keyboard ready flag is 1 is dropped, including in the same cycle as a data read. When this happens, the held character does not change and `kbd_overrun` becomes 1. `kbd_overrun` stays 1 until reset.
- R7: A store to 0xFE06 while the display ready flag is 1 loads `bus_wdata[7:0]` and clears the flag at the next edge. From that edge on, `disp_valid` is 1 and `disp_char` shows the stored character.
- R8: A store to 0xFE06 while the display ready flag is 0 changes neither the held character nor the flag.
- R9: `disp_valid` stays 1 with a stable `disp_char` until a cycle in which `disp_accept` is 1. At the next edge, the display ready flag returns to 1 and `disp_valid` falls.
- R10: When `rst_n` is low at an edge, both enable flags, the keyboard ready flag, `kbd_overrun`, both held characters and `disp_valid` become 0, and the display ready flag becomes 1.
- R11: A store to 0xFE02 or to a memory address changes no register in the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 16 | Bus address |
| bus_rd | input | 1 | Load strobe |
| bus_wr | input | 1 | Store strobe |
| bus_wdata | input | 16 | Store data |
| bus_rdata | output | 16 | Device register word for the current address |
| mem_sel | output | 1 | High when the address is not a device register |
| kbd_valid | input | 1 | Keystroke strobe from the keyboard source |
| kbd_char | input | 8 | Keystroke code |
| kbd_overrun | output | 1 | Sticky flag: a keystroke was dropped |
| disp_valid | output | 1 | Display character pending |
| disp_char | output | 8 | Pending display character |
| disp_accept | input | 1 | Display sink takes the pending character |
| irq_kbd | output | 1 | Keyboard interrupt request |
| irq_disp | output | 1 | Display interrupt request |

## Verification
On every cycle, the assertions check the following:
- keystroke capture, and the locking of input that follows it;
- the clearing of the keyboard ready flag on a data read;
- the dropping and the overrun marking of blocked keystrokes;
- the loading, ignoring, holding and release of display characters;
- the state reached after reset.

Only the bench scenarios can show the address map and the read-back layout of the status words, that a store cannot touch the ready bits, and that stores to the keyboard data word or to memory leave every device register untouched. The bench also covers the full round trips: typing, reading, blocking and re-enabling, and storing, holding and handing off to the display. In these scenarios the interrupt outputs are observed as the flags change.

// File: rtl/mmcon_pkg.sv
// Shared definitions for the keyboard/display controller.
// Assumes: four device registers, indexed in the order listed below.
package mmcon_pkg;
    localparam int unsigned N_REGS = 4;

    typedef enum int unsigned {
        RS_KSTAT = 0,
        RS_KDATA = 1,
        RS_DSTAT = 2,
        RS_DDATA = 3
    } reg_slot_e;
endpackage

// File: rtl/mmcon_decode.sv
// Address decoder: compares the bus address against the four register
// addresses and flags any other address as ordinary memory.
// Assumes: the entries of MAP are distinct.
module mmcon_decode #(
    parameter int unsigned ADDR_W = 16,
    parameter logic [mmcon_pkg::N_REGS-1:0][ADDR_W-1:0] MAP = '0
) (
    input  logic [ADDR_W-1:0]             addr,
    output logic [mmcon_pkg::N_REGS-1:0]  hit,
    output logic                          mem_sel
);
    // One comparator for each device register.
    for (genvar k = 0; k < mmcon_pkg::N_REGS; k++) begin : g_cmp
        assign hit[k] = (addr == MAP[k]);
    end

    // Memory is the source whenever no device register matches.
    assign mem_sel = ~|hit;
endmodule

// File: rtl/mmcon_kbd.sv
// Keyboard channel: captures one character at a time, locks input until the
// processor reads the data word, and marks dropped keystrokes as an overrun.
// Assumes: rd_data is a single-cycle strobe qualified by the address decode.
module mmcon_kbd #(
    parameter int unsigned CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_valid,
    input  logic [CHAR_W-1:0] key_char,
    input  logic              rd_data,
    input  logic              wr_stat,
    input  logic              ie_in,
    output logic              rdy,
    output logic              ie,
    output logic [CHAR_W-1:0] data,
    output logic              ovr,
    output logic              irq
);
    // Ready flag, held character and overrun: capture, clear on read, drop when full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy  <= 1'b0;
            data <= '0;
            ovr  <= 1'b0;
        end else if (!rdy) begin
            if (key_valid) begin
                data <= key_char;
                rdy  <= 1'b1;
            end
        end else begin
            if (key_valid) ovr <= 1'b1;
            if (rd_data)   rdy <= 1'b0;
        end
    end

    // Interrupt enable: the only field a store can change.
    always_ff @(posedge clk) begin
        if (!rst_n)       ie <= 1'b0;
        else if (wr_stat) ie <= ie_in;
    end

    assign irq = rdy & ie;

    p_kb_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid && !rdy |=> rdy && data == $past(key_char));
    p_kb_read_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data && rdy |=> !rdy);
    p_kb_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid && rdy |=> $stable(data) && ovr);
    p_kb_ovr_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ovr |=> ovr);
    p_kb_reset_r10: assert property (@(posedge clk)
        !rst_n |=> !rdy && !ie && !ovr && data == '0);
endmodule

// File: rtl/mmcon_disp.sv
// Display channel: takes one character per store while ready, presents it to
// the sink until it is accepted, and ignores stores while busy.
// Assumes: wr_data is a single-cycle strobe qualified by the address decode.
module mmcon_disp #(
    parameter int unsigned CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_data,
    input  logic [CHAR_W-1:0] wr_char,
    input  logic              wr_stat,
    input  logic              ie_in,
    input  logic              accept,
    output logic              rdy,
    output logic              ie,
    output logic [CHAR_W-1:0] data,
    output logic              valid,
    output logic              irq
);
    // Ready flag and held character: load while ready, release on accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy  <= 1'b1;
            data <= '0;
        end else if (rdy) begin
            if (wr_data) begin
                data <= wr_char;
                rdy  <= 1'b0;
            end
        end else if (accept) begin
            rdy <= 1'b1;
        end
    end

    // Interrupt enable: the only field a store can change.
    always_ff @(posedge clk) begin
        if (!rst_n)       ie <= 1'b0;
        else if (wr_stat) ie <= ie_in;
    end

    assign valid = ~rdy;
    assign irq   = rdy & ie;

    p_dp_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data && rdy |=> !rdy && data == $past(wr_char));
    p_dp_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data && !rdy |=> $stable(data));
    p_dp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy && !accept |=> !rdy && $stable(data));
    p_dp_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy && accept |=> rdy);
    p_dp_reset_r10: assert property (@(posedge clk)
        !rst_n |=> rdy && !ie && data == '0);
endmodule

// File: rtl/mmcon_top.sv
// Memory-mapped keyboard/display controller: decodes the bus address,
// qualifies the load and store strobes, and assembles the read word.
// Assumes: at most one of bus_rd and bus_wr is high in a cycle.
module mmcon_top #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned CHAR_W = 8,
    parameter logic [ADDR_W-1:0] KSTAT_ADDR = 16'hFE00,
    parameter logic [ADDR_W-1:0] KDATA_ADDR = 16'hFE02,
    parameter logic [ADDR_W-1:0] DSTAT_ADDR = 16'hFE04,
    parameter logic [ADDR_W-1:0] DDATA_ADDR = 16'hFE06
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              mem_sel,
    input  logic              kbd_valid,
    input  logic [CHAR_W-1:0] kbd_char,
    output logic              kbd_overrun,
    output logic              disp_valid,
    output logic [CHAR_W-1:0] disp_char,
    input  logic              disp_accept,
    output logic              irq_kbd,
    output logic              irq_disp
);
    import mmcon_pkg::*;

    localparam int unsigned RDY_BIT = DATA_W - 1;
    localparam int unsigned IE_BIT  = DATA_W - 2;
    localparam logic [N_REGS-1:0][ADDR_W-1:0] MAP =
        {DDATA_ADDR, DSTAT_ADDR, KDATA_ADDR, KSTAT_ADDR};

    logic [N_REGS-1:0] hit;
    logic              k_rdy, k_ie, d_rdy, d_ie;
    logic [CHAR_W-1:0] k_data, d_data;
    logic              unused_wdata;

    assign unused_wdata = ^bus_wdata;

    mmcon_decode #(.ADDR_W(ADDR_W), .MAP(MAP)) u_dec (
        .addr    (bus_addr),
        .hit     (hit),
        .mem_sel (mem_sel)
    );

    mmcon_kbd #(.CHAR_W(CHAR_W)) u_kbd (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_valid (kbd_valid),
        .key_char  (kbd_char),
        .rd_data   (bus_rd & hit[RS_KDATA]),
        .wr_stat   (bus_wr & hit[RS_KSTAT]),
        .ie_in     (bus_wdata[IE_BIT]),
        .rdy       (k_rdy),
        .ie        (k_ie),
        .data      (k_data),
        .ovr       (kbd_overrun),
        .irq       (irq_kbd)
    );

    mmcon_disp #(.CHAR_W(CHAR_W)) u_disp (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_data (bus_wr & hit[RS_DDATA]),
        .wr_char (bus_wdata[CHAR_W-1:0]),
        .wr_stat (bus_wr & hit[RS_DSTAT]),
        .ie_in   (bus_wdata[IE_BIT]),
        .accept  (disp_accept),
        .rdy     (d_rdy),
        .ie      (d_ie),
        .data    (d_data),
        .valid   (disp_valid),
        .irq     (irq_disp)
    );

    assign disp_char = d_data;

    // Read word: status flags in the top two bits, characters zero-extended.
    always_comb begin
        bus_rdata = '0;
        if (hit[RS_KSTAT]) begin
            bus_rdata[RDY_BIT] = k_rdy;
            bus_rdata[IE_BIT]  = k_ie;
        end
        if (hit[RS_DSTAT]) begin
            bus_rdata[RDY_BIT] = d_rdy;
            bus_rdata[IE_BIT]  = d_ie;
        end
        if (hit[RS_KDATA]) bus_rdata[CHAR_W-1:0] = k_data;
        if (hit[RS_DDATA]) bus_rdata[CHAR_W-1:0] = d_data;
    end

    p_mem_rdata_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_sel |-> bus_rdata == '0);
endmodule

// File: tb/test_mmcon_top.sv
module test_mmcon_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        mem_sel;
    logic        kbd_valid = 1'b0;
    logic [7:0]  kbd_char = '0;
    logic        kbd_overrun, disp_valid, irq_kbd, irq_disp;
    logic [7:0]  disp_char;
    logic        disp_accept = 1'b0;

    int n_run = 0, n_fail = 0;
    logic [15:0] rv;
    logic        rm;

    always #5 clk = ~clk;

    mmcon_top i_mmcon_top (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mem_sel(mem_sel), .kbd_valid(kbd_valid), .kbd_char(kbd_char),
        .kbd_overrun(kbd_overrun), .disp_valid(disp_valid),
        .disp_char(disp_char), .disp_accept(disp_accept),
        .irq_kbd(irq_kbd), .irq_disp(irq_disp)
    );

    typedef struct packed {
        logic        wr;
        logic [15:0] addr;
        logic [15:0] wd;
        logic [15:0] exp;
        logic        exp_mem;
        logic [23:0] tag;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 16'hFE00, 16'h0000, 16'h0000, 1'b0, "R10"},
        '{1'b0, 16'hFE04, 16'h0000, 16'h8000, 1'b0, "R10"},
        '{1'b0, 16'hFE06, 16'h0000, 16'h0000, 1'b0, "R10"},
        '{1'b1, 16'hFE00, 16'hFFFF, 16'h0000, 1'b0, "R2 "},
        '{1'b0, 16'hFE00, 16'h0000, 16'h4000, 1'b0, "R2 "},
        '{1'b1, 16'hFE04, 16'h7FFF, 16'h0000, 1'b0, "R2 "},
        '{1'b0, 16'hFE04, 16'h0000, 16'hC000, 1'b0, "R2 "},
        '{1'b1, 16'hFE02, 16'h00AB, 16'h0000, 1'b0, "R11"},
        '{1'b0, 16'hFE02, 16'h0000, 16'h0000, 1'b0, "R11"},
        '{1'b0, 16'h3000, 16'h0000, 16'h0000, 1'b1, "R1 "},
        '{1'b0, 16'hFE08, 16'h0000, 16'h0000, 1'b1, "R1 "},
        '{1'b0, 16'hFE01, 16'h0000, 16'h0000, 1'b1, "R1 "},
        '{1'b1, 16'h3000, 16'hFFFF, 16'h0000, 1'b1, "R11"},
        '{1'b0, 16'hFE00, 16'h0000, 16'h4000, 1'b0, "R11"}
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_read(input logic [15:0] a, output logic [15:0] d, output logic m);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        d = bus_rdata; m = mem_sel;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic do_write(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic key(input logic [7:0] c);
        @(negedge clk);
        kbd_valid = 1'b1; kbd_char = c;
        @(posedge clk); #1;
        kbd_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // Vector walk: register map, status layout, writes that must not land.
        for (int i = 0; i < NV; i++) begin
            if (VEC[i].wr) begin
                do_write(VEC[i].addr, VEC[i].wd);
            end else begin
                do_read(VEC[i].addr, rv, rm);
                check($sformatf("%s rdata @%h", VEC[i].tag, VEC[i].addr), rv, VEC[i].exp);
                check($sformatf("%s mem_sel @%h", VEC[i].tag, VEC[i].addr), {15'd0, rm}, {15'd0, VEC[i].exp_mem});
            end
        end
        check("R3 irq_kbd idle", {15'd0, irq_kbd}, 16'd0);
        check("R3 irq_disp ready+enabled", {15'd0, irq_disp}, 16'd1);

        // R4: capture a keystroke
        key(8'h41);
        check("R3 irq_kbd after key", {15'd0, irq_kbd}, 16'd1);
        do_read(16'hFE00, rv, rm);
        check("R4 kbd status after key", rv, 16'hC000);
        do_read(16'hFE02, rv, rm);
        check("R4 kbd data", rv, 16'h0041);
        // R5: the read cleared ready
        do_read(16'hFE00, rv, rm);
        check("R5 kbd status after read", rv, 16'h4000);
        check("R5 irq_kbd after read", {15'd0, irq_kbd}, 16'd0);
        check("R6 no overrun yet", {15'd0, kbd_overrun}, 16'd0);

        // R6: blocked keystroke dropped
        key(8'h5A);
        key(8'h7E);
        check("R6 overrun set", {15'd0, kbd_overrun}, 16'd1);
        do_read(16'hFE02, rv, rm);
        check("R6 held char kept", rv, 16'h005A);
        key(8'h31);
        do_read(16'hFE02, rv, rm);
        check("R5 input re-enabled", rv, 16'h0031);
        check("R6 overrun sticky", {15'd0, kbd_overrun}, 16'd1);

        // R6: keystroke in the same cycle as the data read is dropped
        key(8'h22);
        @(negedge clk);
        bus_addr = 16'hFE02; bus_rd = 1'b1; kbd_valid = 1'b1; kbd_char = 8'h33;
        @(posedge clk); #1;
        bus_rd = 1'b0; kbd_valid = 1'b0;
        do_read(16'hFE00, rv, rm);
        check("R6 same-cycle key dropped", rv, 16'h4000);

        // R7: display store
        do_write(16'hFE06, 16'h1248);
        check("R7 disp_valid", {15'd0, disp_valid}, 16'd1);
        check("R7 disp_char", {8'd0, disp_char}, 16'h0048);
        do_read(16'hFE04, rv, rm);
        check("R7 disp status busy", rv, 16'h4000);
        check("R3 irq_disp busy", {15'd0, irq_disp}, 16'd0);
        // R8: store while busy ignored
        do_write(16'hFE06, 16'h0055);
        check("R8 disp_char unchanged", {8'd0, disp_char}, 16'h0048);
        do_read(16'hFE06, rv, rm);
        check("R8 disp data readback", rv, 16'h0048);
        // R9: holds until accepted
        repeat (3) @(posedge clk);
        #1;
        check("R9 still pending", {15'd0, disp_valid}, 16'd1);
        @(negedge clk);
        disp_accept = 1'b1;
        @(posedge clk); #1;
        disp_accept = 1'b0;
        check("R9 valid dropped", {15'd0, disp_valid}, 16'd0);
        do_read(16'hFE04, rv, rm);
        check("R9 ready again", rv, 16'hC000);
        do_write(16'hFE06, 16'h0077);
        check("R9 next char taken", {8'd0, disp_char}, 16'h0077);

        // R10: reset mid-run
        key(8'h44);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        check("R10 overrun cleared", {15'd0, kbd_overrun}, 16'd0);
        check("R10 disp_valid cleared", {15'd0, disp_valid}, 16'd0);
        check("R10 irq cleared", {14'd0, irq_kbd, irq_disp}, 16'd0);
        rst_n = 1'b1;
        do_read(16'hFE04, rv, rm);
        check("R10 disp status after reset", rv, 16'h8000);
        do_read(16'hFE02, rv, rm);
        check("R10 kbd data after reset", rv, 16'h0000);

        finish_run();
    end
endmodule